// File: doc/BRIEF.md
# Keyboard Matrix Row Scanner

This block walks a key switch matrix of parameterised size (18 rows by 8 columns by default) one row at a time. The row being examined is pulled low and every other row is held high. The column lines are active low and idle high through pullups, so a pressed key in the selected row pulls its column low. Each column line passes through a two-flop synchronizer. A fixed settle delay after the start of each row slot, the block samples the column lines exactly once.

Each column found low during that sample becomes one key event. The event carries the row index and the column index and is offered on a valid/ready output. When several columns are low, their events are offered one at a time, lowest column first. The scan stays in the current row until the last of those events has been accepted, and then finishes the rest of the slot. After the last row the scan returns to row 0, and a one-cycle pulse marks the start of each new sweep.

The slot length is counted in clock cycles. At a 12 MHz clock the default of 8000 cycles gives a slot of about 667 µs and a sweep of about 12 ms.

Top module: `kbd_row_scan`

## Requirements
- R1: During reset and in the first cycle after it, row 0 is the only row driven low, `evt_valid_o` is 0 and `sweep_done_o` is 0.
- R2: In every cycle, exactly one bit of `row_n_o` is 0. Bit i low means row i is selected.
- R3: When no event is pending, each row stays selected for SLOT_CYCLES clock cycles. Rows follow the order 0, 1, …, NUM_ROWS-1 and then return to 0.
- R4: `sweep_done_o` is high for exactly one cycle, and that cycle is the first cycle in which row 0 is selected after row NUM_ROWS-1 has ended.
- R5: The columns are sampled once per slot, after the two-flop synchronizer. A key held in the selected row makes `evt_valid_o` rise SETTLE_CYCLES+1 cycles after the row becomes selected.
- R6: A valid event shows the selected row as a binary index on `evt_row_o`, and the bit position of the low line of `col_n_i` as a binary index on `evt_col_o`.
- R7: If no column is low at the sample point of a slot, no event is produced and the scan moves on to the next row.
- R8: If several columns are low in one slot, each produces exactly one event, in ascending column index. An event is accepted on a clock edge where `evt_valid_o` and `evt_ready_i` are both 1.
- R9: While `evt_valid_o` is 1 and `evt_ready_i` is 0, the event fields and `row_n_o` stay unchanged. The slot counter resumes only after the last pending event has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_n_i | input | NUM_COLS | Raw column lines, active low |
| evt_ready_i | input | 1 | Consumer accepts the offered event |
| row_n_o | output | NUM_ROWS | Row drive lines; the selected row is 0 |
| evt_valid_o | output | 1 | A key event is offered |
| evt_row_o | output | clog2(NUM_ROWS) | Row index of the event |
| evt_col_o | output | clog2(NUM_COLS) | Column index of the event |
| sweep_done_o | output | 1 | One-cycle pulse when a new sweep starts |

## Verification
The row selection changes on the same edge that advances the slot counter, so a new row appears one cycle after the last cycle of the previous slot. The bench checks the row schedule at every falling edge against the number of rising edges since reset. A key event is due SETTLE_CYCLES+1 edges after its row is selected: two edges pass through the synchronizer and one edge loads the pending set. The bench measures this delay from the sweep pulse, which coincides with row 0. Once the pending set is loaded, each accepted event exposes the next column on the following edge. The bench therefore reads one event per falling edge while ready is high, and holds ready low over many edges to confirm that nothing moves.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
    // Default geometry and timing (12 MHz clock, ~667 us per row slot)
    localparam int DEF_ROWS   = 18;
    localparam int DEF_COLS   = 8;
    localparam int DEF_SLOT   = 8000;
    localparam int DEF_SETTLE = 24;
endpackage

// File: rtl/kbd_col_sync.sv
module kbd_col_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Lines idle high, so reset to all ones
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/kbd_first_set.sv
module kbd_first_set #(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o
);
    // Scan downward so the lowest set bit is the last one written
    always_comb begin
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/kbd_row_drive.sv
module kbd_row_drive #(
    parameter int ROWS = 18,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [ROW_W-1:0] sel_i,
    output logic [ROWS-1:0]  row_n_o
);
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign row_n_o[g] = (sel_i != ROW_W'(g));
    end
endmodule

// File: rtl/kbd_row_scan.sv
module kbd_row_scan
    import kbd_scan_pkg::*;
#(
    parameter int NUM_ROWS      = DEF_ROWS,
    parameter int NUM_COLS      = DEF_COLS,
    parameter int SLOT_CYCLES   = DEF_SLOT,
    parameter int SETTLE_CYCLES = DEF_SETTLE,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int CNT_W = $clog2(SLOT_CYCLES)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_COLS-1:0] col_n_i,
    input  logic                evt_ready_i,
    output logic [NUM_ROWS-1:0] row_n_o,
    output logic                evt_valid_o,
    output logic [ROW_W-1:0]    evt_row_o,
    output logic [COL_W-1:0]    evt_col_o,
    output logic                sweep_done_o
);
    localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(NUM_ROWS - 1);

    // The synchronizer needs two edges before a new row is visible,
    // and one cycle must remain after the sample point
    if (SETTLE_CYCLES < 2 || SETTLE_CYCLES > SLOT_CYCLES - 2) begin : g_bad_cfg
        $error("SETTLE_CYCLES must lie in 2 .. SLOT_CYCLES-2");
    end

    typedef struct packed {
        logic [ROW_W-1:0]    row;
        logic [CNT_W-1:0]    cnt;
        logic [NUM_COLS-1:0] pend;
        logic                done;
    } scan_st_t;

    scan_st_t st_d, st_q;

    logic [NUM_COLS-1:0] col_sync;
    logic [NUM_COLS-1:0] pressed;
    logic [COL_W-1:0]    first_col;

    kbd_col_sync #(.WIDTH(NUM_COLS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (col_n_i),
        .sync_o (col_sync)
    );

    assign pressed = ~col_sync;

    kbd_first_set #(.WIDTH(NUM_COLS)) u_pick (
        .vec_i (st_q.pend),
        .idx_o (first_col)
    );

    kbd_row_drive #(.ROWS(NUM_ROWS)) u_drive (
        .sel_i   (st_q.row),
        .row_n_o (row_n_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.pend != '0) begin
            // Drain pending columns; the slot counter is frozen
            if (evt_ready_i) st_d.pend[first_col] = 1'b0;
        end else if (st_q.cnt == SAMPLE_AT) begin
            st_d.pend = pressed;
            st_d.cnt  = st_q.cnt + 1'b1;
        end else if (st_q.cnt == SLOT_LAST) begin
            st_d.cnt = '0;
            if (st_q.row == ROW_LAST) begin
                st_d.row  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign evt_valid_o  = (st_q.pend != '0);
    assign evt_row_o    = st_q.row;
    assign evt_col_o    = first_col;
    assign sweep_done_o = st_q.done;
endmodule

// File: rtl/kbd_scan_chk.sv
module kbd_scan_chk #(
    parameter int NUM_ROWS = 18,
    parameter int NUM_COLS = 8,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                evt_ready_i,
    input logic [NUM_ROWS-1:0] row_n_o,
    input logic                evt_valid_o,
    input logic [ROW_W-1:0]    evt_row_o,
    input logic [COL_W-1:0]    evt_col_o,
    input logic                sweep_done_o
);
    // R2
    one_row_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~row_n_o) == 1);

    // R4
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sweep_done_o |=> !sweep_done_o);

    // R4
    done_row0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sweep_done_o |-> !row_n_o[0]);

    // R6
    evt_row_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_valid_o |-> !row_n_o[evt_row_o]);

    // R9
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_o && !evt_ready_i) |=>
            (evt_valid_o && $stable(evt_row_o) && $stable(evt_col_o) && $stable(row_n_o)));

    // R8
    ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_o && evt_ready_i) |=>
            (!evt_valid_o || (evt_col_o > $past(evt_col_o) && $stable(evt_row_o))));
endmodule

bind kbd_row_scan kbd_scan_chk #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_ready_i  (evt_ready_i),
    .row_n_o      (row_n_o),
    .evt_valid_o  (evt_valid_o),
    .evt_row_o    (evt_row_o),
    .evt_col_o    (evt_col_o),
    .sweep_done_o (sweep_done_o)
);

// File: tb/sim_kbd_row_scan.sv
`timescale 1ns/1ps
module sim_kbd_row_scan;
    localparam int R     = 18;
    localparam int C     = 8;
    localparam int SLOT  = 12;
    localparam int SETL  = 3;
    localparam int SWEEP = R * SLOT;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [C-1:0] col_n;
    logic         ready = 1'b1;
    logic [R-1:0] row_n;
    logic         valid;
    logic [4:0]   erow;
    logic [2:0]   ecol;
    logic         done;

    logic [C-1:0] keys [R];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    kbd_row_scan #(.NUM_ROWS(R), .NUM_COLS(C), .SLOT_CYCLES(SLOT), .SETTLE_CYCLES(SETL)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .col_n_i(col_n), .evt_ready_i(ready),
        .row_n_o(row_n), .evt_valid_o(valid), .evt_row_o(erow), .evt_col_o(ecol),
        .sweep_done_o(done)
    );

    // Matrix model: a pressed key ties its column to a row driven low
    always_comb begin
        col_n = '1;
        for (int r = 0; r < R; r++)
            if (!row_n[r]) col_n = col_n & ~keys[r];
    end

    function automatic int low_row();
        int k = -1;
        for (int r = 0; r < R; r++) if (!row_n[r]) k = r;
        return k;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!valid && n < 3 * SWEEP) begin step(); n++; end
        chk(valid, req, 0, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            summary();
        end
    end

    initial begin
        for (int r = 0; r < R; r++) keys[r] = '0;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk(row_n == ~(R'(1)), "R1", int'(row_n), int'(~(R'(1))));
        chk(!valid && !done, "R1", int'({valid, done}), 0);
        rst_n = 1'b1;
        // R1/R2/R3/R4/R7: idle schedule over two sweeps, t = edges since reset
        for (int t = 0; t <= 2 * SWEEP; t++) begin
            chk(low_row() == (t / SLOT) % R, "R3", low_row(), (t / SLOT) % R);
            chk($countones(~row_n) == 1, "R2", $countones(~row_n), 1);
            chk(done == (t > 0 && t % SWEEP == 0), "R4", int'(done), int'(t > 0 && t % SWEEP == 0));
            chk(!valid, "R7", int'(valid), 0);
            step();
        end

        // R5: latency from the start of row 2 to the event
        keys[2][3] = 1'b1;
        while (!done) step();
        begin
            int n = 0;
            while (!valid && n < SWEEP) begin step(); n++; end
            chk(n == 2 * SLOT + SETL + 1, "R5", n, 2 * SLOT + SETL + 1);
            chk(erow == 2 && ecol == 3, "R6", int'(erow) * 8 + int'(ecol), 19);
        end
        keys[2][3] = 1'b0;
        step();

        // R6: every single key position
        for (int r = 0; r < R; r++) begin
            for (int c = 0; c < C; c++) begin
                keys[r][c] = 1'b1;
                wait_valid("R6");
                chk(int'(erow) == r, "R6", int'(erow), r);
                chk(int'(ecol) == c, "R6", int'(ecol), c);
                keys[r][c] = 1'b0;
                step();
                chk(!valid, "R8", int'(valid), 0);
            end
        end

        // R8: three keys in row 5, taken in ascending order
        keys[5] = 8'b1001_0010;
        wait_valid("R8");
        chk(ecol == 1 && erow == 5, "R8", int'(ecol), 1);
        keys[5] = '0;
        step();
        chk(valid && ecol == 4, "R8", int'(ecol), 4);
        step();
        chk(valid && ecol == 7, "R8", int'(ecol), 7);
        step();
        chk(!valid, "R8", int'(valid), 0);

        // R9: back-pressure holds the event and the row
        ready = 1'b0;
        keys[4] = 8'b0100_0100;
        wait_valid("R9");
        keys[4] = '0;
        chk(ecol == 2 && erow == 4, "R9", int'(ecol), 2);
        for (int i = 0; i < 3 * SLOT; i++) begin
            step();
            chk(valid && ecol == 2 && low_row() == 4, "R9", low_row(), 4);
        end
        ready = 1'b1;
        step();
        chk(valid && ecol == 6, "R9", int'(ecol), 6);
        step();
        chk(!valid && low_row() == 4, "R9", low_row(), 4);

        finished = 1;
        summary();
    end
endmodule